// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block sits between a single-master internal request bus and up to four external asynchronous static devices, such as parallel NOR flash or SRAM. The devices share one non-multiplexed 24-bit halfword address bus and one 16-bit data bus, and each device has its own active-low chip select. The controller claims one fixed 256 MB byte window and splits it into four equal regions, one region for each chip select. It runs each access as a sequence of phases counted in system clock cycles: an address setup phase, an optional address hold phase, a data phase with output enable or write enable low, a release cycle, and a programmable bus turnaround. A short fixed gap comes before the next access when the pair of access types calls for one.

Every bank has its own read timing set. When a bank's extended mode is on, its writes use a second timing set, and read and write can each add an address hold phase. Writes reach a bank only while that bank's write-enable bit is set. The master holds a request valid until the controller pulses ready for one cycle, so only one access is ever in flight.

Top module: `smemBusCtrl`

## Requirements
- R1: The window is byte addresses 0x6000_0000 to 0x6FFF_FFFF. Address bits [27:26] select the bank, and memCsN[b] goes low only for bank b. At most one chip select is low at any time.
- R2: memAddr carries reqAddr[24:1] and stays stable while a chip select is low.
- R3: The address phase lasts max(setup,1) cycles. During it the chip select is low and both strobes are high.
- R4: The data phase lasts max(data,1) cycles. memWeN is low for exactly that phase on writes and memOeN on reads, and never both. Write data is driven (memDoe high) whenever memWeN is low.
- R5: Read data is sampled on the last data-phase cycle and returned in rspRdata together with ready. The chip select and strobes are released for one cycle after the data phase, so a read without hold phase spans setup + data + 1 cycles.
- R6: After the release cycle, the turnaround field adds that many cycles with every chip select high before ready. Ready never coincides with a low chip select.
- R7: A fixed gap of one cycle with all chip selects high comes before an access whenever an earlier access has completed since reset. The gap is zero only when a write follows a write to the same bank and that bank's extended mode is off.
- R8: With extended mode on, the per-type hold-select bit (read or write) adds an address hold phase of max(hold,1) cycles between the address and data phases. With extended mode off there is no hold phase.
- R9: Each timing set is 20 bits per bank at [b*20 +: 20]: [19:16] hold, [15:12] setup, [11:4] data, [3:0] turnaround. Reads always use cfgRdTiming. Writes use cfgWrTiming when that bank's cfgExtEn bit is set, and cfgRdTiming otherwise.
- R10: A write to a bank whose cfgWrEn bit is clear drives no chip select or strobe, leaves the device contents unchanged and does not count as the previous access for R7.
- R11: A request outside the window, not halfword aligned, or with reqAddr[25] set completes without any chip select. For such a request rspRdata is 0.
- R12: Counting the accepting edge as 1, the ready pulse comes in the cycle after edge 1+gap+setup+hold+data+1+turnaround, or right after the accepting edge for requests that R10 or R11 turns away. Ready is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request valid, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, valid with reqReady |
| cfgRdTiming | input | 80 | Read timing sets, 20 bits per bank |
| cfgWrTiming | input | 80 | Write timing sets, 20 bits per bank |
| cfgExtEn | input | 4 | Per-bank extended mode |
| cfgHoldRd | input | 4 | Per-bank hold phase on reads (extended mode) |
| cfgHoldWr | input | 4 | Per-bank hold phase on writes (extended mode) |
| cfgWrEn | input | 4 | Per-bank write enable |
| memCsN | output | 4 | Active-low chip selects |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | 24 | Halfword address |
| memDout | output | 16 | Write data to devices |
| memDoe | output | 1 | Data bus drive enable |
| memDin | input | 16 | Read data from devices |

## Verification
Every access result is due at a cycle that follows from the programmed counts. Ready arrives 2+gap+setup+hold+data+turnaround sampling points after the request is raised, or 1 point after it for requests that are turned away. The bench samples on the falling edge and counts each falling edge from the one where the request is driven. While it waits it tallies the falling edges with a chip select low, with a strobe low, and with the chip select low before the first strobe, and compares each tally with the value computed from the settings. Read data is taken from rspRdata at the ready sample, and the bench then confirms that ready has dropped one sample later.

// File: rtl/smemPkg.sv
package smemPkg;
  localparam int HLD_W = 4;
  localparam int SET_W = 4;
  localparam int DST_W = 8;
  localparam int TRN_W = 4;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic [HLD_W-1:0] addHld;
    logic [SET_W-1:0] addSet;
    logic [DST_W-1:0] dataSt;
    logic [TRN_W-1:0] turn;
  } timing_t;

  localparam int TIMING_W = $bits(timing_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_ADDR, PH_HOLD, PH_DATA, PH_REL, PH_TURN, PH_ACK
  } phase_e;

  typedef struct packed {
    logic loadReq;
    logic capture;
    logic selCs;
    logic selOe;
    logic selWe;
    logic drvData;
  } strobe_t;
endpackage

// File: rtl/smemDecode.sv
module smemDecode #(
  parameter int          ADDR_W    = 24,
  parameter int          NUM_BANKS = 4,
  parameter int          WIN_BITS  = 28,
  parameter logic [31:0] WIN_BASE  = 32'h6000_0000,
  localparam int         BANK_BITS = $clog2(NUM_BANKS),
  localparam int         REG_BITS  = WIN_BITS - BANK_BITS
) (
  input  logic [31:0]          reqAddr,
  output logic                 hit,
  output logic [BANK_BITS-1:0] bankSel
);
  logic inWindow;
  logic aligned;
  logic inReach;

  assign inWindow = (reqAddr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
  assign aligned  = (reqAddr[0] == 1'b0);
  assign bankSel  = reqAddr[WIN_BITS-1 -: BANK_BITS];

  // Region bits above the device address reach must be zero.
  generate
    if (REG_BITS > ADDR_W + 1) begin : g_reach
      assign inReach = (reqAddr[REG_BITS-1:ADDR_W+1] == '0);
    end else begin : g_full
      assign inReach = 1'b1;
    end
  endgenerate

  assign hit = inWindow && aligned && inReach;
endmodule

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
#(
  parameter int  NUM_BANKS = 4,
  localparam int BANK_BITS = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic                          hit,
  input  logic [BANK_BITS-1:0]          bankSel,
  input  timing_t [NUM_BANKS-1:0]       rdTiming,
  input  timing_t [NUM_BANKS-1:0]       wrTiming,
  input  logic [NUM_BANKS-1:0]          extEn,
  input  logic [NUM_BANKS-1:0]          holdRd,
  input  logic [NUM_BANKS-1:0]          holdWr,
  input  logic [NUM_BANKS-1:0]          wrEn,
  output strobe_t                       strobe,
  output logic                          reqReady
);
  phase_e               phase;
  logic [CNT_W-1:0]     cnt;
  timing_t              curT;
  logic                 curHold;
  logic                 curWrite;
  logic [BANK_BITS-1:0] curBank;
  logic                 lastValid;
  logic                 lastWrite;
  logic [BANK_BITS-1:0] lastBank;

  logic    selExt;
  timing_t selT;
  logic    selHold;
  logic    allowed;
  logic    gapNeed;
  logic    cntZero;

  function automatic logic [CNT_W-1:0] lenM1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign selExt  = extEn[bankSel];
  assign selT    = (reqWrite && selExt) ? wrTiming[bankSel] : rdTiming[bankSel];
  assign selHold = selExt && (reqWrite ? holdWr[bankSel] : holdRd[bankSel]);
  assign allowed = hit && (!reqWrite || wrEn[bankSel]);
  assign gapNeed = lastValid &&
                   !(lastWrite && reqWrite && (lastBank == bankSel) && !selExt);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      curT      <= '0;
      curHold   <= 1'b0;
      curWrite  <= 1'b0;
      curBank   <= '0;
      lastValid <= 1'b0;
      lastWrite <= 1'b0;
      lastBank  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (reqValid) begin
          curT     <= selT;
          curHold  <= selHold;
          curWrite <= reqWrite;
          curBank  <= bankSel;
          if (!allowed) begin
            phase <= PH_ACK;
          end else if (gapNeed) begin
            phase <= PH_GAP;
          end else begin
            phase <= PH_ADDR;
            cnt   <= lenM1(CNT_W'(selT.addSet));
          end
        end
        PH_GAP: begin
          phase <= PH_ADDR;
          cnt   <= lenM1(CNT_W'(curT.addSet));
        end
        PH_ADDR: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (curHold) begin
            phase <= PH_HOLD;
            cnt   <= lenM1(CNT_W'(curT.addHld));
          end else begin
            phase <= PH_DATA;
            cnt   <= lenM1(CNT_W'(curT.dataSt));
          end
        end
        PH_HOLD: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else begin
            phase <= PH_DATA;
            cnt   <= lenM1(CNT_W'(curT.dataSt));
          end
        end
        PH_DATA: begin
          if (!cntZero) cnt <= cnt - 1'b1;
          else          phase <= PH_REL;
        end
        PH_REL: begin
          lastValid <= 1'b1;
          lastWrite <= curWrite;
          lastBank  <= curBank;
          if (curT.turn == '0) begin
            phase <= PH_ACK;
          end else begin
            phase <= PH_TURN;
            cnt   <= CNT_W'(curT.turn) - 1'b1;
          end
        end
        PH_TURN: begin
          if (!cntZero) cnt <= cnt - 1'b1;
          else          phase <= PH_ACK;
        end
        PH_ACK:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.loadReq = (phase == PH_IDLE) && reqValid;
    strobe.capture = (phase == PH_DATA) && cntZero && !curWrite;
    strobe.selCs   = (phase == PH_ADDR) || (phase == PH_HOLD) || (phase == PH_DATA);
    strobe.selOe   = (phase == PH_DATA) && !curWrite;
    strobe.selWe   = (phase == PH_DATA) && curWrite;
    strobe.drvData = curWrite && (strobe.selCs || (phase == PH_REL));
  end

  assign reqReady = (phase == PH_ACK);
endmodule

// File: rtl/smemDatapath.sv
module smemDatapath
  import smemPkg::*;
#(
  parameter int  ADDR_W    = 24,
  parameter int  DATA_W    = 16,
  parameter int  NUM_BANKS = 4,
  localparam int BANK_BITS = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [ADDR_W-1:0]    reqHalfAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic [DATA_W-1:0]    memDin,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memDout,
  output logic                 memDoe,
  output logic [DATA_W-1:0]    rspRdata
);
  logic [ADDR_W-1:0]    addrReg;
  logic [DATA_W-1:0]    wdataReg;
  logic [DATA_W-1:0]    rdataReg;
  logic [BANK_BITS-1:0] bankReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      bankReg  <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrReg  <= reqHalfAddr;
        wdataReg <= reqWdata;
        bankReg  <= bankSel;
        rdataReg <= '0;
      end else if (strobe.capture) begin
        rdataReg <= memDin;
      end
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      assign memCsN[b] = !(strobe.selCs && (bankReg == BANK_BITS'(b)));
    end
  endgenerate

  assign memOeN   = !strobe.selOe;
  assign memWeN   = !strobe.selWe;
  assign memAddr  = addrReg;
  assign memDout  = wdataReg;
  assign memDoe   = strobe.drvData;
  assign rspRdata = rdataReg;
endmodule

// File: rtl/smemBusCtrl.sv
module smemBusCtrl
  import smemPkg::*;
#(
  parameter int  ADDR_W    = 24,
  parameter int  DATA_W    = 16,
  parameter int  NUM_BANKS = 4,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int CFG_W     = NUM_BANKS * TIMING_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [31:0]          reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqReady,
  output logic [DATA_W-1:0]    rspRdata,
  input  logic [CFG_W-1:0]     cfgRdTiming,
  input  logic [CFG_W-1:0]     cfgWrTiming,
  input  logic [NUM_BANKS-1:0] cfgExtEn,
  input  logic [NUM_BANKS-1:0] cfgHoldRd,
  input  logic [NUM_BANKS-1:0] cfgHoldWr,
  input  logic [NUM_BANKS-1:0] cfgWrEn,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memDout,
  output logic                 memDoe,
  input  logic [DATA_W-1:0]    memDin
);
  timing_t [NUM_BANKS-1:0] rdT;
  timing_t [NUM_BANKS-1:0] wrT;
  logic                    hit;
  logic [BANK_BITS-1:0]    bankSel;
  strobe_t                 strobe;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cfg
      assign rdT[b] = cfgRdTiming[b*TIMING_W +: TIMING_W];
      assign wrT[b] = cfgWrTiming[b*TIMING_W +: TIMING_W];
    end
  endgenerate

  smemDecode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) decode_i (
    .reqAddr (reqAddr),
    .hit     (hit),
    .bankSel (bankSel)
  );

  smemCtrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .hit      (hit),
    .bankSel  (bankSel),
    .rdTiming (rdT),
    .wrTiming (wrT),
    .extEn    (cfgExtEn),
    .holdRd   (cfgHoldRd),
    .holdWr   (cfgHoldWr),
    .wrEn     (cfgWrEn),
    .strobe   (strobe),
    .reqReady (reqReady)
  );

  smemDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqHalfAddr (reqAddr[ADDR_W:1]),
    .reqWdata    (reqWdata),
    .bankSel     (bankSel),
    .memDin      (memDin),
    .memCsN      (memCsN),
    .memOeN      (memOeN),
    .memWeN      (memWeN),
    .memAddr     (memAddr),
    .memDout     (memDout),
    .memDoe      (memDoe),
    .rspRdata    (rspRdata)
  );
endmodule

// File: rtl/smemBusCtrlChk.sv
module smemBusCtrlChk #(
  parameter int ADDR_W    = 24,
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic [NUM_BANKS-1:0] memCsN,
  input logic                 memOeN,
  input logic                 memWeN,
  input logic                 memDoe,
  input logic [ADDR_W-1:0]    memAddr,
  input logic [NUM_BANKS-1:0] cfgWrEn
);
  // R1: never more than one device selected
  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R2: address held steady across consecutive selected cycles
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!(&memCsN) && !(&$past(memCsN))) |-> $stable(memAddr));

  // R3: a write strobe is always preceded by a selected address cycle
  assert_setup_before_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> !(&$past(memCsN)));

  // R4: strobes exclusive, and each needs a selected device
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_strobe_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> $onehot(~memCsN));

  assert_we_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDoe);

  // R6: completion only with every device deselected
  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (&memCsN));

  // R10: write strobe only towards a write-enabled bank
  assert_write_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> ((~memCsN & cfgWrEn) != '0));

  // R12: ready lasts one cycle
  assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);
endmodule

bind smemBusCtrl smemBusCtrlChk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .memCsN   (memCsN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memDoe   (memDoe),
  .memAddr  (memAddr),
  .cfgWrEn  (cfgWrEn)
);

// File: tb/smemBusCtrl_tb_top.sv
module smemBusCtrl_tb_top;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [31:0]   reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady;
  logic [DW-1:0] rspRdata;
  logic [79:0]   cfgRdTiming;
  logic [79:0]   cfgWrTiming;
  logic [NB-1:0] cfgExtEn, cfgHoldRd, cfgHoldWr, cfgWrEn;
  logic [NB-1:0] memCsN;
  logic          memOeN, memWeN, memDoe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout;
  logic [DW-1:0] memDin;

  logic [15:0] mem [64];
  int total = 0;
  int bad = 0;

  // measured per access
  int mLat, mCs, mOe, mWe, mPre;
  logic [AW-1:0] mAddr;
  logic [NB-1:0] mCsSeen;
  logic [DW-1:0] mRdata;

  always #4 clk = ~clk;

  function automatic logic [1:0] bankIdx(input logic [NB-1:0] cs);
    logic [1:0] r = 2'd0;
    for (int i = 0; i < NB; i++) if (!cs[i]) r = 2'(i);
    return r;
  endfunction

  function automatic logic [15:0] initVal(input int i);
    return 16'h1000 + 16'(i) * 16'h0101;
  endfunction

  assign memDin = (!memOeN) ? mem[{bankIdx(memCsN), memAddr[3:0]}] : 16'h0000;

  smemBusCtrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .cfgRdTiming(cfgRdTiming), .cfgWrTiming(cfgWrTiming),
    .cfgExtEn(cfgExtEn), .cfgHoldRd(cfgHoldRd), .cfgHoldWr(cfgHoldWr),
    .cfgWrEn(cfgWrEn), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drives one request at a falling edge and measures it at falling edges.
  task automatic runAccess(input logic wr, input logic [31:0] a, input logic [DW-1:0] d);
    int n = 0;
    mCs = 0; mOe = 0; mWe = 0; mPre = 0; mAddr = '0; mCsSeen = '1; mRdata = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    forever begin
      @(negedge clk);
      n++;
      if (memCsN != '1) begin
        mCs++;
        mCsSeen = memCsN;
        mAddr = memAddr;
        if (memOeN && memWeN && mOe == 0 && mWe == 0) mPre++;
      end
      if (!memWeN) begin
        mWe++;
        mem[{bankIdx(memCsN), memAddr[3:0]}] = memDout;
      end
      if (!memOeN) mOe++;
      if (reqReady) begin
        mRdata = rspRdata;
        reqValid = 1'b0;
        break;
      end
      if (n > 300) begin
        reqValid = 1'b0;
        break;
      end
    end
    mLat = n;
    @(negedge clk);
    checkEq("R12 ready single cycle", int'(reqReady), 0);
  endtask

  task automatic testReset;
    checkEq("R1 reset chip selects", int'(memCsN), 'hF);
    checkEq("R4 reset strobes", int'({memOeN, memWeN, memDoe}), 'b110);
    checkEq("R12 reset ready", int'(reqReady), 0);
  endtask

  task automatic testBasicRead;
    // bank0: setup2 data3 turn1, first access no gap
    runAccess(1'b0, 32'h6000_0004, '0);
    checkEq("R12 R5 read latency", mLat, 8);
    checkEq("R3 setup cycles", mPre, 2);
    checkEq("R4 oe cycles", mOe, 3);
    checkEq("R5 cs cycles", mCs, 5);
    checkEq("R1 bank0 select", int'(mCsSeen), 'hE);
    checkEq("R2 halfword addr", int'(mAddr), 2);
    checkEq("R5 read data", int'(mRdata), int'(initVal(2)));
  endtask

  task automatic testWriteGaps;
    runAccess(1'b1, 32'h6000_0006, 16'hA5A5);
    checkEq("R7 write after read gap", mLat, 9);
    checkEq("R4 we cycles", mWe, 3);
    runAccess(1'b1, 32'h6000_0008, 16'h5A5A);
    checkEq("R7 same bank write no gap", mLat, 8);
    runAccess(1'b0, 32'h6000_0006, '0);
    checkEq("R7 read after write gap", mLat, 9);
    checkEq("R5 read back", int'(mRdata), 'hA5A5);
  endtask

  task automatic testOtherBank;
    // bank1: setup1 data2 turn0
    runAccess(1'b1, 32'h6400_0010, 16'h0BEE);
    checkEq("R6 zero turnaround latency", mLat, 6);
    checkEq("R1 bank1 select", int'(mCsSeen), 'hD);
    checkEq("R2 bank1 addr", int'(mAddr), 8);
    runAccess(1'b1, 32'h6000_000A, 16'h7777);
    checkEq("R7 write to other bank gap", mLat, 9);
  endtask

  task automatic testExtended;
    // bank2 writes: hold3 setup1 data2 turn1 with hold phase
    runAccess(1'b1, 32'h6800_0002, 16'hC0DE);
    checkEq("R9 R8 ext write latency", mLat, 10);
    checkEq("R8 setup plus hold", mPre, 4);
    checkEq("R9 write timing data", mWe, 2);
    runAccess(1'b1, 32'h6800_0004, 16'hBEEF);
    checkEq("R7 ext same bank write keeps gap", mLat, 10);
    // bank2 reads: setup3 data4 turn2, no hold
    runAccess(1'b0, 32'h6800_0002, '0);
    checkEq("R9 read timing latency", mLat, 12);
    checkEq("R6 R3 read setup", mPre, 3);
    checkEq("R4 ext read oe", mOe, 4);
    checkEq("R5 ext read data", int'(mRdata), 'hC0DE);
    // bank3 reads: hold field 0 gives 1
    runAccess(1'b0, 32'h6C00_0000, '0);
    checkEq("R8 minimum hold", mLat, 9);
    checkEq("R8 hold in address span", mPre, 3);
  endtask

  task automatic testGateAndWindow;
    runAccess(1'b1, 32'h6C00_0000, 16'h1234);
    checkEq("R10 gated write latency", mLat, 1);
    checkEq("R10 gated write no cs", mCs, 0);
    checkEq("R10 gated write no we", mWe, 0);
    runAccess(1'b0, 32'h6C00_0000, '0);
    checkEq("R10 contents unchanged", int'(mRdata), int'(initVal(48)));
    checkEq("R10 gated write not previous", mLat, 9);
    runAccess(1'b0, 32'h7000_0000, '0);
    checkEq("R11 outside window latency", mLat, 1);
    checkEq("R11 outside window no cs", mCs, 0);
    checkEq("R11 outside window data", int'(mRdata), 0);
    runAccess(1'b0, 32'h6000_0003, '0);
    checkEq("R11 misaligned no cs", mCs, 0);
    runAccess(1'b0, 32'h6200_0000, '0);
    checkEq("R11 beyond reach no cs", mCs, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = initVal(i);
    // per bank {hold, setup, data, turn}
    cfgRdTiming = {{4'd0, 4'd2, 8'd2, 4'd1},
                   {4'd0, 4'd3, 8'd4, 4'd2},
                   {4'd0, 4'd1, 8'd2, 4'd0},
                   {4'd0, 4'd2, 8'd3, 4'd1}};
    cfgWrTiming = {{4'd0, 4'd1, 8'd1, 4'd0},
                   {4'd3, 4'd1, 8'd2, 4'd1},
                   {4'd0, 4'd1, 8'd1, 4'd0},
                   {4'd0, 4'd1, 8'd1, 4'd0}};
    cfgExtEn  = 4'b1100;
    cfgHoldRd = 4'b1000;
    cfgHoldWr = 4'b0100;
    cfgWrEn   = 4'b0111;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBasicRead();
    testWriteGaps();
    testOtherBank();
    testExtended();
    testGateAndWindow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired R12 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule